// File: doc/BRIEF.md
# Beam-Sync Serial Event Decoder

This block recovers 8-bit event codes from a beam-sync serial line. The line carries a carrier at one seventh of the RF clock, so every bit cell spans exactly 14 ticks of a sampling clock running at twice the RF frequency. Each cell begins with a transition. A logic 1 adds a second transition near the middle of the cell, and a logic 0 has none. An idle line therefore shows a steady carrier of zeros. A frame consists of a start bit of 1, then eight data bits with the most significant bit first, then a parity bit chosen so that the nine data and parity bits hold an odd number of ones.

The line first passes through a two-stage synchronizer and an edge detector. A cell timer then locks onto the boundary transitions, counts ticks inside each cell, notes any transition in the middle window and reports the bit value at a fixed sample tick. A frame state machine finds the start bit, shifts in the byte and checks parity. A registered output stage strobes valid bytes. It also raises a separate strobe for the revolution marker code 0xAA. One instance serves one beam-sync line, so a system with two rings uses two instances.

Cell timer states: `CELL_SEEK`, in which any edge locks the timer and moves it to `CELL_TRACK`. In `CELL_TRACK`, an edge at tick 11 or later marks a boundary and restarts the count. The first edge at ticks 3 to 9 marks a mid-cell transition. Any other edge, or reaching tick 13 with no edge, is a loss of lock and returns the timer to `CELL_SEEK`. Frame states: `FRM_WAIT` moves to `FRM_DATA` when a sampled 1 arrives as the start bit. `FRM_DATA` moves to `FRM_PARITY` after eight bits. `FRM_PARITY` returns to `FRM_WAIT` when the parity bit is sampled. A loss of lock sends any state back to `FRM_WAIT`.

Top module: `bsync_event_decoder`

## Requirements
- R1: While reset is held, and after it is released, `event_stb`, `mark_stb` and `parity_err` are low and `event_code` is 0x00.
- R2: A well-formed frame makes `event_stb` pulse for exactly one clock, with `event_code` equal to the received byte. `event_code` holds that value until the next accepted event.
- R3: `mark_stb` pulses in the same clock as `event_stb` exactly when the accepted byte is 0xAA. Any other code leaves `mark_stb` low.
- R4: The parity bit makes the count of ones over the data and parity bits odd. A frame that breaks this rule pulses `parity_err` for one clock, gives no `event_stb`, and leaves `event_code` unchanged.
- R5: An idle carrier, meaning boundary transitions only, never produces `event_stb`, `mark_stb` or `parity_err`.
- R6: Data bits arrive with the most significant bit first: the first data cell after the start bit becomes bit 7 of `event_code`.
- R7: If a cell reaches tick 13 after its boundary with no new transition, or a transition falls outside both timing windows, the frame in progress is dropped with no strobe and no error. The decoder then relocks on the next transition and decodes the following frames.
- R8: A start bit may follow the parity cell of the previous frame directly, with no idle cell between, and both frames are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Sampling clock at twice the RF frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsync_line | input | 1 | Raw beam-sync serial line, asynchronous |
| event_code | output | 8 | Last accepted event byte |
| event_stb | output | 1 | One-clock strobe for an accepted byte |
| mark_stb | output | 1 | One-clock strobe for the revolution marker 0xAA |
| parity_err | output | 1 | One-clock pulse for a frame with bad parity |

## Verification
The assertions check four rules on every cycle. The event strobe is one clock wide. The code stays put between strobes. The marker strobe only ever comes with an event strobe carrying 0xAA. A parity error never comes with an event strobe. A separate assertion checks that a loss of lock always returns the frame machine to its waiting state. Only the bench scenarios can show that the byte arrives in the correct bit order and with the correct value. The same applies to correct parity judgement, to an idle carrier staying silent, to recovery after the line stalls in mid-frame, and to back-to-back frames both being decoded.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    typedef enum logic {
        CELL_SEEK,
        CELL_TRACK
    } cell_state_e;

    typedef enum logic [1:0] {
        FRM_WAIT,
        FRM_DATA,
        FRM_PARITY
    } frame_state_e;

endpackage

// File: rtl/bsync_line_sync.sv
module bsync_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    always_comb edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/bsync_cell_timer.sv
module bsync_cell_timer
    import bsync_pkg::*;
#(
    parameter int CELL_TICKS = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic cell_done_o,
    output logic cell_bit_o,
    output logic lost_o
);
    localparam int CNT_W = $clog2(CELL_TICKS);
    localparam int HALF  = CELL_TICKS / 2;
    localparam logic [CNT_W-1:0] MID_LO    = CNT_W'(HALF - 4);
    localparam logic [CNT_W-1:0] MID_HI    = CNT_W'(HALF + 2);
    localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(HALF + 3);
    localparam logic [CNT_W-1:0] BOUND_LO  = CNT_W'(HALF + 4);
    localparam logic [CNT_W-1:0] LAST      = CNT_W'(CELL_TICKS - 1);

    cell_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mid_q, mid_d;
    logic             lost;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CELL_SEEK;
            cnt_q <= '0;
            mid_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            mid_q <= mid_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        mid_d = mid_q;
        lost  = 1'b0;
        unique case (st_q)
            CELL_SEEK: begin
                if (edge_i) begin
                    st_d  = CELL_TRACK;
                    cnt_d = '0;
                    mid_d = 1'b0;
                end
            end
            CELL_TRACK: begin
                if (edge_i) begin
                    if (cnt_q >= BOUND_LO) begin
                        cnt_d = '0;
                        mid_d = 1'b0;
                    end else if (cnt_q >= MID_LO && cnt_q <= MID_HI && !mid_q) begin
                        mid_d = 1'b1;
                        cnt_d = cnt_q + 1'b1;
                    end else begin
                        lost = 1'b1;
                    end
                end else if (cnt_q == LAST) begin
                    lost = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = CELL_SEEK;
        endcase
        if (lost) begin
            st_d  = CELL_SEEK;
            cnt_d = '0;
            mid_d = 1'b0;
        end
    end

    always_comb begin
        cell_done_o = (st_q == CELL_TRACK) && (cnt_q == SAMPLE_AT) && !edge_i;
        cell_bit_o  = mid_q;
        lost_o      = lost;
    end

endmodule

// File: rtl/bsync_frame_fsm.sv
module bsync_frame_fsm
    import bsync_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_done_i,
    input  logic              cell_bit_i,
    input  logic              lost_i,
    output logic              ok_o,
    output logic              bad_o,
    output logic [CODE_W-1:0] byte_o
);
    localparam int NB_W = $clog2(CODE_W);
    localparam logic [NB_W-1:0] NB_LAST = NB_W'(CODE_W - 1);

    frame_state_e      state_q, state_d;
    logic [CODE_W-1:0] sh_q, sh_d;
    logic [NB_W-1:0]   nb_q, nb_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRM_WAIT;
            sh_q    <= '0;
            nb_q    <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            nb_q    <= nb_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        nb_d    = nb_q;
        unique case (state_q)
            FRM_WAIT: begin
                if (cell_done_i && cell_bit_i) begin
                    state_d = FRM_DATA;
                    nb_d    = '0;
                end
            end
            FRM_DATA: begin
                if (cell_done_i) begin
                    sh_d = {sh_q[CODE_W-2:0], cell_bit_i};
                    nb_d = nb_q + 1'b1;
                    if (nb_q == NB_LAST) state_d = FRM_PARITY;
                end
            end
            FRM_PARITY: begin
                if (cell_done_i) state_d = FRM_WAIT;
            end
            default: state_d = FRM_WAIT;
        endcase
        if (lost_i) state_d = FRM_WAIT;
    end

    always_comb begin
        ok_o   = (state_q == FRM_PARITY) && cell_done_i && ((^sh_q) ^ cell_bit_i);
        bad_o  = (state_q == FRM_PARITY) && cell_done_i && !((^sh_q) ^ cell_bit_i);
        byte_o = sh_q;
    end

    // R7: loss of cell lock abandons any frame in progress
    assert_abort_on_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost_i |=> (state_q == FRM_WAIT));

endmodule

// File: rtl/bsync_event_decoder.sv
module bsync_event_decoder #(
    parameter int                 CELL_TICKS  = 14,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 CODE_W      = 8,
    parameter logic [CODE_W-1:0]  MARK_CODE   = 8'hAA
) (
    input  logic              clk_2x,
    input  logic              rst_n,
    input  logic              bsync_line,
    output logic [CODE_W-1:0] event_code,
    output logic              event_stb,
    output logic              mark_stb,
    output logic              parity_err
);
    logic              line_edge;
    logic              cell_done, cell_bit, cell_lost;
    logic              frm_ok, frm_bad;
    logic [CODE_W-1:0] frm_byte;

    bsync_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_2x),
        .rst_n  (rst_n),
        .line_i (bsync_line),
        .edge_o (line_edge)
    );

    bsync_cell_timer #(.CELL_TICKS(CELL_TICKS)) u_timer (
        .clk         (clk_2x),
        .rst_n       (rst_n),
        .edge_i      (line_edge),
        .cell_done_o (cell_done),
        .cell_bit_o  (cell_bit),
        .lost_o      (cell_lost)
    );

    bsync_frame_fsm #(.CODE_W(CODE_W)) u_frame (
        .clk         (clk_2x),
        .rst_n       (rst_n),
        .cell_done_i (cell_done),
        .cell_bit_i  (cell_bit),
        .lost_i      (cell_lost),
        .ok_o        (frm_ok),
        .bad_o       (frm_bad),
        .byte_o      (frm_byte)
    );

    always_ff @(posedge clk_2x or negedge rst_n) begin
        if (!rst_n) begin
            event_code <= '0;
            event_stb  <= 1'b0;
            mark_stb   <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            event_stb  <= frm_ok;
            mark_stb   <= frm_ok && (frm_byte == MARK_CODE);
            parity_err <= frm_bad;
            if (frm_ok) event_code <= frm_byte;
        end
    end

    assert_stb_one_clock_R2: assert property (@(posedge clk_2x) disable iff (!rst_n)
        event_stb |=> !event_stb);

    assert_code_held_R2: assert property (@(posedge clk_2x) disable iff (!rst_n)
        !event_stb |-> $stable(event_code));

    assert_mark_with_code_R3: assert property (@(posedge clk_2x) disable iff (!rst_n)
        mark_stb |-> (event_stb && event_code == MARK_CODE));

    assert_err_excludes_stb_R4: assert property (@(posedge clk_2x) disable iff (!rst_n)
        parity_err |-> !event_stb);

endmodule

// File: tb/sim_bsync_event_decoder.sv
module sim_bsync_event_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b0;
    logic       lvl = 1'b0;
    logic [7:0] event_code;
    logic       event_stb, mark_stb, parity_err;

    int n_checks = 0, n_errors = 0;
    int n_stb = 0, n_mark = 0, n_err = 0, run = 0, max_run = 0;
    logic [7:0] log_c [0:7];
    bit done = 0;

    always #2.5 clk = ~clk;

    bsync_event_decoder u0 (
        .clk_2x(clk), .rst_n(rst_n), .bsync_line(line),
        .event_code(event_code), .event_stb(event_stb),
        .mark_stb(mark_stb), .parity_err(parity_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (event_stb) begin
                if (n_stb < 8) log_c[n_stb] = event_code;
                n_stb++;
            end
            if (mark_stb) n_mark++;
            if (parity_err) n_err++;
            run = event_stb ? run + 1 : 0;
            if (run > max_run) max_run = run;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_stb = 0; n_mark = 0; n_err = 0; run = 0; max_run = 0;
    endtask

    task automatic send_cell(input bit b);
        lvl = ~lvl; line = lvl;
        repeat (7) @(negedge clk);
        if (b) begin lvl = ~lvl; line = lvl; end
        repeat (7) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send_cell(1'b0);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit good);
        send_cell(1'b1);
        for (int i = 7; i >= 0; i--) send_cell(b[i]);
        send_cell(good ? ~^b : ^b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 stb", event_stb, 0);
        chk("R1 mark", mark_stb, 0);
        chk("R1 err", parity_err, 0);
        chk("R1 code", event_code, 0);
    endtask

    task automatic t_idle();
        clear_mon();
        idle(20);
        chk("R5 idle stb", n_stb, 0);
        chk("R5 idle err", n_err + n_mark, 0);
    endtask

    task automatic t_event();
        clear_mon();
        send_frame(8'h3C, 1'b1); idle(2);
        chk("R2 count", n_stb, 1);
        chk("R2 code", event_code, 8'h3C);
        chk("R2 width", max_run, 1);
        chk("R3 no mark", n_mark, 0);
        idle(5);
        chk("R2 held", event_code, 8'h3C);
    endtask

    task automatic t_order();
        clear_mon();
        send_frame(8'h01, 1'b1); idle(2);
        chk("R6 lsb code", event_code, 8'h01);
        send_frame(8'h80, 1'b1); idle(2);
        chk("R6 msb code", event_code, 8'h80);
        chk("R6 count", n_stb, 2);
    endtask

    task automatic t_mark();
        clear_mon();
        send_frame(8'hAA, 1'b1); idle(2);
        chk("R3 mark count", n_mark, 1);
        chk("R3 mark code", event_code, 8'hAA);
        clear_mon();
        send_frame(8'h55, 1'b1); idle(2);
        chk("R3 no mark 55", n_mark, 0);
        chk("R3 stb 55", n_stb, 1);
    endtask

    task automatic t_parity();
        clear_mon();
        send_frame(8'h5A, 1'b0); idle(2);
        chk("R4 err", n_err, 1);
        chk("R4 no stb", n_stb, 0);
        chk("R4 code kept", event_code, 8'h55);
    endtask

    task automatic t_loss();
        clear_mon();
        send_cell(1'b1); send_cell(1'b1); send_cell(1'b0); send_cell(1'b1);
        repeat (40) @(negedge clk);
        chk("R7 no stb", n_stb, 0);
        chk("R7 no err", n_err, 0);
        idle(3);
        send_frame(8'h96, 1'b1); idle(2);
        chk("R7 recover", event_code, 8'h96);
        chk("R7 count", n_stb, 1);
    endtask

    task automatic t_b2b();
        clear_mon();
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1); idle(2);
        chk("R8 count", n_stb, 2);
        chk("R8 first", log_c[0], 8'h12);
        chk("R8 second", log_c[1], 8'h34);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_event();
        t_order();
        t_mark();
        t_parity();
        t_loss();
        t_b2b();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule